// File: doc/BRIEF.md
# Main Control and ALU Function Decoder

This block turns one 32-bit instruction word of a 64-bit load/store machine into the control signals that steer the datapath. It drives the source-register select, the second-operand select, the write-back source select, the register write enable, the memory read and write strobes, and the conditional and unconditional branch flags. It also drives a 2-bit ALU class and a 4-bit ALU function. The block has no clock and no state. It sits between the instruction memory output and the register file, ALU and data memory, which lie outside it.

The instruction formats do not share one opcode length. The opcode sits in the top bits of the word and is 6, 8, 9, 10 or 11 bits long, depending on the format. The first level compares the top bits against left-aligned prefixes, each under its own length mask, and finds the instruction class. From that class it sets the main controls and a 2-bit ALU class. The second level works the 4-bit ALU function out of the ALU class and the opcode bits. The block also reports a 3-bit format code, which tells the immediate extender which field to take.

Top module: `ctl_decode_top`

## Requirements
- R1: The ALU class `alu_op` is 00 (add) for LDUR, STUR, B and unrecognised words. It is 01 (pass second operand) for CBZ and MOVZ. It is 10 (function taken from the opcode) for ADD, SUB, AND, ORR, ADDI and SUBI.
- R2: `alu_fn` is 0010 when `alu_op` is 00 and 0111 when it is 01. When it is 10, the function comes from the opcode as follows. If instr[24]=1 the function is 0110 when instr[30]=1 and 0010 otherwise. If instr[24]=0 it is 0001 when instr[29]=1 and 0000 otherwise.
- R3: The register-format opcodes in instr[31:21] are ADD 10001011000, SUB 11001011000, AND 10001010000 and ORR 10101010000. Each one asserts only `reg_write`, with `alu_op`=10.
- R4: LDUR (instr[31:21]=11111000010) asserts `alu_src`, `mem_to_reg`, `reg_write` and `mem_read`, and nothing else.
- R5: STUR (instr[31:21]=11111000000) asserts `reg2loc`, `alu_src` and `mem_write`. It never asserts `reg_write`, `mem_read` or `mem_to_reg`.
- R6: CBZ (instr[31:24]=10110100) asserts `reg2loc` and `branch` only. B (instr[31:26]=000101) asserts `uncond_branch` only.
- R7: ADDI (instr[31:22]=1001000100), SUBI (instr[31:22]=1101000100) and MOVZ (instr[31:23]=110100101) assert `alu_src` and `reg_write`, and nothing else.
- R8: Only the opcode prefix of the matched format affects the outputs. The bits below the prefix do not, and at most one prefix matches any word.
- R9: A word that matches no opcode drives every control flag low, with `alu_op`=00 and `fmt`=0.
- R10: `fmt` is 0 for unrecognised words, 1 for register format, 2 for LDUR and STUR, 3 for ADDI and SUBI, 4 for MOVZ, 5 for CBZ and 6 for B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being decoded |
| reg2loc | output | 1 | Second read register from bits 4:0 instead of 20:16 |
| alu_src | output | 1 | ALU second operand from the extended immediate |
| mem_to_reg | output | 1 | Write-back data from data memory instead of the ALU |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read strobe |
| mem_write | output | 1 | Data memory write strobe |
| branch | output | 1 | Conditional branch on zero result |
| uncond_branch | output | 1 | Unconditional branch |
| alu_op | output | 2 | ALU class for the second-level decoder |
| alu_fn | output | 4 | ALU function code |
| fmt | output | 3 | Instruction format code |

## Verification
The block holds no state. A fault in the decode therefore appears on the ports for the same word that causes it and vanishes when the word changes. A prefix mask that is too wide or too narrow shows in two ways. A word with random low bits loses its class, or a near-miss opcode gains one. Either way every control flag and `fmt` change at once. A wrong second-level mapping shows only on `alu_fn` for the arithmetic and logical classes, while the main controls stay correct.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 11;
  localparam int OPC_MSB = INSTR_W - 1;
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int NUM_OPS = 11;
  localparam int CLS_W   = $clog2(NUM_OPS + 1);
  localparam int AOP_W   = 2;
  localparam int FN_W    = 4;
  localparam int FMT_W   = 3;

  // opcode bit positions inside the 11-bit opcode slice
  localparam int OPC_SUB_BIT = 9;  // word bit 30
  localparam int OPC_OR_BIT  = 8;  // word bit 29
  localparam int OPC_ART_BIT = 3;  // word bit 24

  typedef enum logic [AOP_W-1:0] {
    AOP_ADD   = 2'b00,
    AOP_PASSB = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_RSVD  = 2'b11
  } aluop_e;

  typedef enum logic [FN_W-1:0] {
    FN_AND   = 4'b0000,
    FN_OR    = 4'b0001,
    FN_ADD   = 4'b0010,
    FN_SUB   = 4'b0110,
    FN_PASSB = 4'b0111
  } alufn_e;

  typedef enum logic [FMT_W-1:0] {
    FMT_NONE = 3'd0,
    FMT_REG  = 3'd1,
    FMT_MEM  = 3'd2,
    FMT_IMM  = 3'd3,
    FMT_WIDE = 3'd4,
    FMT_CBR  = 3'd5,
    FMT_JMP  = 3'd6
  } fmt_e;

  // class index = table slot + 1; slot order matches op_pat/op_len
  typedef enum logic [CLS_W-1:0] {
    CLS_NONE = 4'd0,
    CLS_ADD  = 4'd1,
    CLS_SUB  = 4'd2,
    CLS_AND  = 4'd3,
    CLS_ORR  = 4'd4,
    CLS_LDUR = 4'd5,
    CLS_STUR = 4'd6,
    CLS_ADDI = 4'd7,
    CLS_SUBI = 4'd8,
    CLS_MOVZ = 4'd9,
    CLS_CBZ  = 4'd10,
    CLS_B    = 4'd11
  } cls_e;

  typedef struct packed {
    logic   reg2loc;
    logic   alu_src;
    logic   mem_to_reg;
    logic   reg_write;
    logic   mem_read;
    logic   mem_write;
    logic   branch;
    logic   uncond;
    aluop_e alu_op;
    fmt_e   fmt;
  } ctl_t;

  // left-aligned opcode prefix for each table slot
  function automatic logic [OPC_W-1:0] op_pat(input int k);
    case (k)
      0:       return 11'b10001011000;
      1:       return 11'b11001011000;
      2:       return 11'b10001010000;
      3:       return 11'b10101010000;
      4:       return 11'b11111000010;
      5:       return 11'b11111000000;
      6:       return 11'b10010001000;
      7:       return 11'b11010001000;
      8:       return 11'b11010010100;
      9:       return 11'b10110100000;
      default: return 11'b00010100000;
    endcase
  endfunction

  // number of significant prefix bits for each slot
  function automatic int op_len(input int k);
    case (k)
      0, 1, 2, 3, 4, 5: return 11;
      6, 7:             return 10;
      8:                return 9;
      9:                return 8;
      default:          return 6;
    endcase
  endfunction

  function automatic logic [OPC_W-1:0] len_mask(input int len);
    return ~({OPC_W{1'b1}} >> len);
  endfunction

  function automatic logic prefix_hit(input logic [OPC_W-1:0] opc, input int k);
    return ((opc ^ op_pat(k)) & len_mask(op_len(k))) == '0;
  endfunction

  // second-level ALU function selection
  function automatic alufn_e alu_fn_of(input aluop_e op, input logic [OPC_W-1:0] opc);
    alufn_e fn;
    case (op)
      AOP_PASSB: fn = FN_PASSB;
      AOP_FUNCT: begin
        if (opc[OPC_ART_BIT]) fn = opc[OPC_SUB_BIT] ? FN_SUB : FN_ADD;
        else                  fn = opc[OPC_OR_BIT]  ? FN_OR  : FN_AND;
      end
      default:   fn = FN_ADD;
    endcase
    return fn;
  endfunction

endpackage

// File: rtl/opc_prefix_match.sv
module opc_prefix_match
  import ctl_dec_pkg::*;
#(
  parameter int NUM = NUM_OPS
) (
  input  logic [OPC_W-1:0] opc,
  output logic [NUM-1:0]   hit
);

  for (genvar k = 0; k < NUM; k++) begin : g_slot
    assign hit[k] = prefix_hit(opc, k);
  end

endmodule

// File: rtl/op_class_enc.sv
module op_class_enc
  import ctl_dec_pkg::*;
#(
  parameter int NUM = NUM_OPS
) (
  input  logic [NUM-1:0] hit,
  output cls_e           cls
);

  always_comb begin
    cls = CLS_NONE;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (hit[k]) cls = cls_e'(CLS_W'(k + 1));
    end
  end

endmodule

// File: rtl/main_ctl_dec.sv
module main_ctl_dec
  import ctl_dec_pkg::*;
(
  input  cls_e cls,
  output ctl_t ctl
);

  always_comb begin
    ctl        = '0;
    ctl.alu_op = AOP_ADD;
    ctl.fmt    = FMT_NONE;
    case (cls)
      CLS_ADD, CLS_SUB, CLS_AND, CLS_ORR: begin
        ctl.reg_write = 1'b1;
        ctl.alu_op    = AOP_FUNCT;
        ctl.fmt       = FMT_REG;
      end
      CLS_LDUR: begin
        ctl.alu_src    = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_write  = 1'b1;
        ctl.mem_read   = 1'b1;
        ctl.fmt        = FMT_MEM;
      end
      CLS_STUR: begin
        ctl.reg2loc   = 1'b1;
        ctl.alu_src   = 1'b1;
        ctl.mem_write = 1'b1;
        ctl.fmt       = FMT_MEM;
      end
      CLS_ADDI, CLS_SUBI: begin
        ctl.alu_src   = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_op    = AOP_FUNCT;
        ctl.fmt       = FMT_IMM;
      end
      CLS_MOVZ: begin
        ctl.alu_src   = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_op    = AOP_PASSB;
        ctl.fmt       = FMT_WIDE;
      end
      CLS_CBZ: begin
        ctl.reg2loc = 1'b1;
        ctl.branch  = 1'b1;
        ctl.alu_op  = AOP_PASSB;
        ctl.fmt     = FMT_CBR;
      end
      CLS_B: begin
        ctl.uncond = 1'b1;
        ctl.fmt    = FMT_JMP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_fn_dec.sv
module alu_fn_dec
  import ctl_dec_pkg::*;
(
  input  aluop_e           alu_op,
  input  logic [OPC_W-1:0] opc,
  output alufn_e           fn
);

  assign fn = alu_fn_of(alu_op, opc);

endmodule

// File: rtl/ctl_decode_top.sv
module ctl_decode_top
  import ctl_dec_pkg::*;
(
  input  logic [31:0] instr,
  output logic        reg2loc,
  output logic        alu_src,
  output logic        mem_to_reg,
  output logic        reg_write,
  output logic        mem_read,
  output logic        mem_write,
  output logic        branch,
  output logic        uncond_branch,
  output logic [1:0]  alu_op,
  output logic [3:0]  alu_fn,
  output logic [2:0]  fmt
);

  logic [OPC_W-1:0]   opc;
  logic [NUM_OPS-1:0] op_hit;
  cls_e               op_cls;
  ctl_t               ctl;
  alufn_e             fn;
  logic               unused_operand_bits;

  assign opc                 = instr[OPC_MSB:OPC_LSB];
  assign unused_operand_bits = ^instr[OPC_LSB-1:0];

  opc_prefix_match #(.NUM(NUM_OPS)) i_match (
    .opc (opc),
    .hit (op_hit)
  );

  op_class_enc #(.NUM(NUM_OPS)) i_enc (
    .hit (op_hit),
    .cls (op_cls)
  );

  main_ctl_dec i_main (
    .cls (op_cls),
    .ctl (ctl)
  );

  alu_fn_dec i_alu (
    .alu_op (ctl.alu_op),
    .opc    (opc),
    .fn     (fn)
  );

  assign reg2loc       = ctl.reg2loc;
  assign alu_src       = ctl.alu_src;
  assign mem_to_reg    = ctl.mem_to_reg;
  assign reg_write     = ctl.reg_write;
  assign mem_read      = ctl.mem_read;
  assign mem_write     = ctl.mem_write;
  assign branch        = ctl.branch;
  assign uncond_branch = ctl.uncond;
  assign alu_op        = ctl.alu_op;
  assign alu_fn        = fn;
  assign fmt           = ctl.fmt;

endmodule

// File: rtl/ctl_decode_chk.sv
module ctl_decode_chk
  import ctl_dec_pkg::*;
(
  input logic [31:0]        instr,
  input logic [NUM_OPS-1:0] op_hit,
  input logic               reg2loc,
  input logic               mem_to_reg,
  input logic               reg_write,
  input logic               mem_read,
  input logic               mem_write,
  input logic               branch,
  input logic               uncond_branch,
  input logic [1:0]         alu_op,
  input logic [3:0]         alu_fn,
  input logic [2:0]         fmt
);

  always_comb begin
    if (!$isunknown(instr)) begin
      assert_one_prefix_R8: assert ($onehot0(op_hit))
        else $error("more than one opcode prefix matched");
      assert_store_no_wb_R5: assert (!mem_write || (!reg_write && !mem_read && reg2loc))
        else $error("store strobe with write-back or read");
      assert_load_path_R4: assert (!mem_to_reg || (mem_read && reg_write))
        else $error("memory write-back without load");
      assert_branch_quiet_R6: assert (!(branch || uncond_branch) || (!reg_write && !mem_write && !mem_read))
        else $error("branch with a write or read");
      assert_pass_fn_R2: assert (alu_op != 2'b01 || alu_fn == 4'b0111)
        else $error("pass class without pass function");
      assert_unknown_idle_R9: assert (op_hit != '0 ||
        (fmt == 3'd0 && !reg_write && !mem_write && !mem_read && !branch && !uncond_branch))
        else $error("unmatched word drives controls");
      assert_one_class_R10: assert ($countones({branch, uncond_branch, mem_write}) <= 1)
        else $error("conflicting control classes");
    end
  end

endmodule

bind ctl_decode_top ctl_decode_chk i_chk (.*);

// File: tb/test_ctl_decode_top.sv
module test_ctl_decode_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        reg2loc, alu_src, mem_to_reg, reg_write, mem_read, mem_write;
  logic        branch, uncond_branch;
  logic [1:0]  alu_op;
  logic [3:0]  alu_fn;
  logic [2:0]  fmt;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ctl_decode_top i_ctl_decode_top (
    .instr(instr), .reg2loc(reg2loc), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_write(reg_write), .mem_read(mem_read), .mem_write(mem_write),
    .branch(branch), .uncond_branch(uncond_branch), .alu_op(alu_op),
    .alu_fn(alu_fn), .fmt(fmt)
  );

  // expected {8 flags, alu_op, fmt}
  function automatic logic [12:0] model_ctl(input logic [31:0] w);
    logic [7:0] f;
    logic [1:0] a;
    logic [2:0] t;
    f = 8'b0; a = 2'b00; t = 3'd0;
    casez (w[31:21])
      11'b10001011000, 11'b11001011000,
      11'b10001010000, 11'b10101010000: begin f = 8'b0001_0000; a = 2'b10; t = 3'd1; end
      11'b11111000010: begin f = 8'b0111_1000; t = 3'd2; end
      11'b11111000000: begin f = 8'b1100_0100; t = 3'd2; end
      11'b1001000100?, 11'b1101000100?: begin f = 8'b0101_0000; a = 2'b10; t = 3'd3; end
      11'b110100101??: begin f = 8'b0101_0000; a = 2'b01; t = 3'd4; end
      11'b10110100???: begin f = 8'b1000_0010; a = 2'b01; t = 3'd5; end
      11'b000101?????: begin f = 8'b0000_0001; t = 3'd6; end
      default: ;
    endcase
    return {f, a, t};
  endfunction

  function automatic logic [3:0] model_fn(input logic [31:0] w);
    logic [1:0] a;
    a = model_ctl(w)[4:3];
    if (a == 2'b01) return 4'b0111;
    if (a != 2'b10) return 4'b0010;
    if (w[24]) return w[30] ? 4'b0110 : 4'b0010;
    return w[29] ? 4'b0001 : 4'b0000;
  endfunction

  function automatic string flag_req(input logic [31:0] w);
    logic [2:0] t;
    t = model_ctl(w)[2:0];
    case (t)
      3'd1: return "R3";
      3'd2: return w[22] ? "R4" : "R5";
      3'd3, 3'd4: return "R7";
      3'd5, 3'd6: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, instr, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input string extra);
    logic [12:0] e;
    @(posedge clk);
    #1 instr = w;
    @(negedge clk);
    e = model_ctl(w);
    check(flag_req(w), "flags",
          {24'b0, reg2loc, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, uncond_branch},
          {24'b0, e[12:5]});
    check("R1", "alu_op", {30'b0, alu_op}, {30'b0, e[4:3]});
    check("R2", "alu_fn", {28'b0, alu_fn}, {28'b0, model_fn(w)});
    check("R10", "fmt", {29'b0, fmt}, {29'b0, e[2:0]});
    if (extra != "") check(extra, "prefix-only", {19'b0, e}, {19'b0, reg2loc, alu_src, mem_to_reg,
          reg_write, mem_read, mem_write, branch, uncond_branch, alu_op, fmt});
  endtask

  function automatic logic [31:0] with_op(input int sel, input logic [31:0] r);
    logic [31:0] w;
    w = r;
    case (sel)
      0:  w[31:21] = 11'b10001011000;
      1:  w[31:21] = 11'b11001011000;
      2:  w[31:21] = 11'b10001010000;
      3:  w[31:21] = 11'b10101010000;
      4:  w[31:21] = 11'b11111000010;
      5:  w[31:21] = 11'b11111000000;
      6:  w[31:22] = 10'b1001000100;
      7:  w[31:22] = 10'b1101000100;
      8:  w[31:23] = 9'b110100101;
      9:  w[31:24] = 8'b10110100;
      10: w[31:26] = 6'b000101;
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // idle word after reset: R9
    apply(32'h0000_0000, "R9");
    // directed corners
    apply(32'hFFFF_FFFF, "R9");                           // all ones, no opcode
    apply(with_op(4, 32'h0) | 32'h0020_0000 ^ 32'h0020_0000 | 32'h0060_0000, "R9"); // near-miss LDUR 11111000011
    apply({8'b10110101, 24'hABCDEF}, "R9");              // near-miss CBZ
    apply(with_op(0, 32'hFFFF_FFFF), "R8");               // ADD, low bits all ones
    apply(with_op(10, 32'hFFFF_FFFF), "R8");              // B, low bits all ones
    apply(with_op(9, 32'h0), "R8");                       // CBZ, low bits zero
    for (int s = 0; s < 11; s++) apply(with_op(s, 32'h0), "");
    for (int s = 0; s < 11; s++) apply(with_op(s, 32'h5A5A_5A5A), "R8");
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom % 14);
      apply(with_op(sel, $urandom), "R8");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule